// File: doc/BRIEF.md
# Clear-to-Send Gated Serial Transmitter

This block serialises bytes into asynchronous frames with eight data bits, no parity and one stop bit. It takes each byte from a transmit queue through a valid/ready handshake. A baud-tick strobe sets the bit timing, and every bit is held for a fixed number of ticks. The serial line rests high whenever no frame is in progress.

When automatic flow control is switched on, an active-low clear-to-send input gates the start of each byte. A byte begins from idle only while that input is low. While a frame is on the wire, the decision about the following byte is taken once, at the middle of the stop bit. A frame that has begun always runs to its end. When the input returns low, any waiting bytes go out.

With flow control off, the input has no effect on sending. Each edge on it then produces a one-cycle interrupt pulse. With flow control on, those pulses are withheld. The clear-to-send input is synchronised inside the block with two flops.

Top module: `cts_uart_tx`

## Requirements
- R1: A frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts 16 baud ticks.
- R2: After reset the line `txd` is high, `busy` is low and `cts_irq` is low. `txd` is high whenever no frame is in progress.
- R3: With `auto_cts_en` low, a byte offered on `tx_valid` is sent whatever level `cts_n` has.
- R4: With `auto_cts_en` high and the block idle, no byte starts while the synchronised `cts_n` is high.
- R5: If `cts_n` is high at the stop-bit midpoint (tick 8 of the stop bit), the current frame completes and the next byte waits.
- R6: If `cts_n` is low at the stop-bit midpoint, a byte waiting at the end of that stop bit starts at once, even if `cts_n` has since gone high.
- R7: A frame that has started is never cut short by `cts_n` going high. All ten bits are sent.
- R8: When `cts_n` goes from high to low, a held byte is sent.
- R9: With `auto_cts_en` low, each edge of `cts_n` produces one single-cycle pulse on `cts_irq`. With it high, `cts_irq` stays low.
- R10: `busy` is high from the start bit through the end of the stop bit.
- R11: `tx_ready` is high only when a byte can begin in that cycle: from idle, or at the last tick of a stop bit. A byte is taken when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit time |
| auto_cts_en | input | 1 | Enables automatic clear-to-send gating |
| tx_data | input | 8 | Byte offered by the transmit queue |
| tx_valid | input | 1 | Queue holds a byte |
| tx_ready | output | 1 | Byte is taken this cycle if valid |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| cts_irq | output | 1 | One-cycle pulse per `cts_n` edge, only with gating off |

## Verification
The assertions assume that `auto_cts_en` is changed only while the block is idle. They also assume that `tx_data` holds steady while `tx_valid` waits for `tx_ready`. The bench changes the gating mode only after the line has drained, and its queue model presents the head byte until the handshake completes. Every `cts_n` change is placed several cycles away from a stop-bit midpoint, so the two-flop synchroniser cannot move a decision across that boundary. The baud strobe is free-running with a fixed divider, so each bit lasts a whole number of cycles that the bench knows.

// File: rtl/cts_tx_pkg.sv
package cts_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // Tick count at which a bit ends.
  function automatic int unsigned last_tick(int unsigned per_bit);
    return per_bit - 1;
  endfunction

  // Tick count at which the midpoint event of a bit fires (count is zero-based).
  function automatic int unsigned mid_tick(int unsigned per_bit);
    return per_bit / 2 - 1;
  endfunction
endpackage

// File: rtl/cts_watch.sv
module cts_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_cts_en,
  output logic cts_ok,
  output logic cts_irq
);
  logic s1, s2, s3;
  logic cts_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= cts_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign cts_edge = s2 ^ s3;
  assign cts_ok   = !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_irq <= 1'b0;
    else        cts_irq <= cts_edge && !auto_cts_en;
  end

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_cts_en) |-> !cts_irq);
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cts_irq |=> !cts_irq);
endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              stop_mid,
  output logic              stop_end
);
  import cts_tx_pkg::*;

  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(last_tick(TICKS_PER_BIT));
  localparam logic [CW-1:0] MID  = CW'(mid_tick(TICKS_PER_BIT));
  localparam logic [IW-1:0] TOPB = IW'(DATA_W - 1);

  tx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              bit_end;

  assign bit_end  = baud_tick && (cnt == LAST) && (state != ST_IDLE);
  assign stop_end = bit_end && (state == ST_STOP);
  assign stop_mid = baud_tick && (cnt == MID) && (state == ST_STOP);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
    end else if (load) begin
      state <= ST_START;
      cnt   <= '0;
      idx   <= '0;
      sh    <= load_data;
    end else if (baud_tick && state != ST_IDLE) begin
      if (cnt == LAST) begin
        cnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
            if (idx == TOPB) state <= ST_STOP;
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end

  p_no_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_end) |=> busy);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_mid_before_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mid |-> !stop_end);
endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              auto_cts_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              cts_n,
  output logic              txd,
  output logic              busy,
  output logic              cts_irq
);
  logic cts_ok;
  logic stop_mid, stop_end;
  logic commit_q;
  logic load;

  cts_watch u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n       (cts_n),
    .auto_cts_en (auto_cts_en),
    .cts_ok      (cts_ok),
    .cts_irq     (cts_irq)
  );

  tx_frame_engine #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .DATA_W        (DATA_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load      (load),
    .load_data (tx_data),
    .txd       (txd),
    .busy      (busy),
    .stop_mid  (stop_mid),
    .stop_end  (stop_end)
  );

  // Decision for the following byte, taken once per frame at the stop midpoint.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        commit_q <= 1'b0;
    else if (stop_mid) commit_q <= cts_ok;
  end

  assign tx_ready = (!busy && (!auto_cts_en || cts_ok)) ||
                    (stop_end && (!auto_cts_en || commit_q));
  assign load     = tx_valid && tx_ready;

  p_gate_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && auto_cts_en) |-> cts_ok);
  p_hold_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && auto_cts_en && !commit_q) |=> !busy);
  p_ready_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && busy) |-> stop_end);
  p_line_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
endmodule

// File: tb/sim_cts_uart_tx.sv
module sim_cts_uart_tx;
  localparam int TDIV = 2;
  localparam int BIT  = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       auto_cts_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       cts_n = 1'b1;
  logic       txd, busy, cts_irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int div = 0;
  logic [7:0] pend[$];
  logic [7:0] expq[$];
  event stop_seen;

  always #4 clk = ~clk;

  always @(posedge clk) div <= (div == TDIV - 1) ? 0 : div + 1;
  assign baud_tick = (div == TDIV - 1);

  cts_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .auto_cts_en(auto_cts_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .cts_n(cts_n),
    .txd(txd), .busy(busy), .cts_irq(cts_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    pend.push_back(b);
    expq.push_back(b);
  endtask

  task automatic wait_drain();
    int t = 0;
    while ((pend.size() != 0 || expq.size() != 0 || busy) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Queue model: present the head byte, retire it after a handshake.
  bit took = 0;
  always @(negedge clk) begin
    if (took) void'(pend.pop_front());
    tx_valid = (pend.size() != 0);
    tx_data  = tx_valid ? pend[0] : 8'h00;
    took     = tx_valid && tx_ready && rst_n;
  end

  always @(negedge clk) if (rst_n && cts_irq) irq_cnt++;

  // Monitor: decode frames from the line and score them.
  initial begin
    logic [7:0] got;
    logic       st, sp;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (8 * TDIV) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        sp = txd;
        check(busy == 1'b1, "R10", "busy during stop bit", busy, 1);
        check(st == 1'b0 && sp == 1'b1, "R1", "start/stop levels", {st, sp}, 2'b01);
        if (expq.size() == 0) begin
          check(1'b0, "R1", "unexpected byte", got, -1);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(got == e, "R1/R7", "byte bit0-first", got, e);
        end
        -> stop_seen;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R2", "txd in reset", txd, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R2", "idle after reset", {txd, busy}, 2'b10);
    check(cts_irq == 1'b0, "R2", "irq after reset", cts_irq, 0);

    // R3: gating off, CTS high is ignored
    push(8'hA5); push(8'h3C); push(8'h01);
    wait_drain();
    check(pend.size() == 0, "R3", "bytes sent with cts high", pend.size(), 0);
    check(irq_cnt == 0, "R9", "no irq without edges", irq_cnt, 0);

    // R9: edges raise pulses with gating off
    irq_cnt = 0;
    cts_n = 1'b0; repeat (10) @(negedge clk);
    cts_n = 1'b1; repeat (10) @(negedge clk);
    check(irq_cnt == 2, "R9", "irq pulses with gating off", irq_cnt, 2);

    // R4/R11: gating on, idle and CTS high holds
    auto_cts_en = 1'b1;
    irq_cnt = 0;
    repeat (4) @(negedge clk);
    push(8'h5A);
    repeat (400) @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1, "R4", "held while cts high", {busy, txd}, 2'b01);
    check(tx_ready == 1'b0, "R11", "ready low while held", tx_ready, 0);
    check(expq.size() == 1, "R4", "byte not sent", expq.size(), 1);
    cts_n = 1'b0;
    wait_drain();
    check(expq.size() == 0, "R8", "resumed after cts low", expq.size(), 0);

    // R5/R7: CTS high during data bits of first byte
    push(8'h81); push(8'h7E);
    while (!busy) @(negedge clk);
    repeat (60) @(negedge clk);
    cts_n = 1'b1;
    while (busy) @(negedge clk);
    repeat (300) @(negedge clk);
    check(pend.size() == 1 && busy == 1'b0, "R5", "next byte held", pend.size(), 1);
    check(expq.size() == 1, "R7", "first frame completed", expq.size(), 1);
    cts_n = 1'b0;
    wait_drain();
    check(expq.size() == 0, "R8", "held byte released", expq.size(), 0);

    // R6: CTS high only after stop midpoint
    push(8'hC3); push(8'h99); push(8'h42);
    @(stop_seen);
    repeat (TDIV) @(negedge clk);
    cts_n = 1'b1;
    repeat (700) @(negedge clk);
    check(expq.size() == 1, "R6", "committed byte sent", expq.size(), 1);
    check(pend.size() == 1 && busy == 1'b0, "R6", "third byte held", pend.size(), 1);
    cts_n = 1'b0;
    wait_drain();
    check(expq.size() == 0, "R8", "all drained", expq.size(), 0);
    check(irq_cnt == 0, "R9", "no irq with gating on", irq_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule